// File: doc/BRIEF.md
# Two-Stage Indexed Register Front End for a Dual-Channel Serial Controller

This block sits between a host bus and the configuration state of a two-channel serial controller. Each channel offers a control port and a data port. Most registers are reached in two steps through the control port. The first write, made while the channel's index pointer is at zero, is a command byte, and its low four bits load the pointer. The next control-port access, whether a read or a write, reaches the register that the pointer names. The pointer then drops back to zero. Data-port accesses skip the pointer and go straight to transmit or receive data.

The block keeps the write registers of both channels. The interrupt vector (index 2) and master interrupt control (index 9) are single registers that both channels share. Bit 0 of register 15 decides whether index 7 reaches the sync-character register or the alternate option register. Bit 6 of the alternate option register turns on read-back of selected write registers. Command fields of registers 9 and 14 are sent out as one-cycle events and are not stored. Read indexes that map to live serializer state are fetched through a combinational lookup port. A timer enforces a minimum spacing between accesses. Any access that arrives too early is flagged and has no other effect.

Top module: `sio_regfront`

## Requirements
- R1: After reset, both channel pointers are 0 and every bit of `wreg_img` is 0. A control read with the pointer at 0 is routed to live index 0.
- R2: A control-port write with the channel pointer at 0 emits a command event (kind 0) carrying the byte and loads the pointer from bits 3:0. The next control access on that channel uses that index, and the pointer is then 0 again. Each channel has its own pointer.
- R3: A data-port write emits a transmit event (kind 1) with the byte. A data-port read returns live index 8. Neither changes the pointer. A control write at index 8 also emits a transmit event.
- R4: A write to index 2 or index 9 from either channel goes to one shared register. Its value appears in slot 2 (or 9) of both channels' views in `wreg_img`, where channel c, slot s occupies bits [(c*16+s)*8 +: 8].
- R5: A write at index 7 is stored in slot 7 (sync character) when bit 0 of that channel's slot 15 is 0, and in slot 8 (alternate options) when that bit is 1.
- R6: While bit 6 of the channel's slot 8 is 1, reads at indexes 4, 5, 9 and 11 return slots 4, 5, 3 and 10. While that bit is 0, those reads go to the live port.
- R7: Reads at indexes 12, 13 and 15 return the stored slots. A read at index 14 returns 0. Reads at 0, 1, 2, 3, 6, 7, 8 and 10 return `live_val` for (`acc_ch`, index).
- R8: A write at index 9 stores only bits 5:0. If bits 7:6 are nonzero, it emits a reset event (kind 2) whose value is that 2-bit code (1 = channel A, 2 = channel B, 3 = hardware).
- R9: A write at index 14 stores only bits 4:0. If bits 7:5 are nonzero, it emits a clock-recovery command event (kind 3) whose value is that 3-bit code.
- R10: An access that arrives fewer than GAP_CYC cycles after the last accepted access raises `gap_viol` in the next cycle. It changes no register and no pointer, and produces no event and no read. An access exactly GAP_CYC cycles later is accepted.
- R11: `rd_valid`/`rd_data` and `evt_valid`/`evt_kind`/`evt_ch`/`evt_val` are single-cycle outputs that appear in the cycle after the accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_dport | input | 1 | 1 = data port, 0 = control port |
| acc_ch | input | CHW | Channel of the access |
| acc_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| live_ch | output | CHW | Channel for live lookup |
| live_idx | output | 4 | Read index for live lookup |
| live_val | input | 8 | Live register value |
| gap_viol | output | 1 | Spacing violation pulse |
| evt_valid | output | 1 | Event pulse |
| evt_kind | output | 2 | 0 command, 1 transmit, 2 reset, 3 clock-recovery |
| evt_ch | output | CHW | Event channel |
| evt_val | output | 8 | Event payload |
| wreg_img | output | NCH*16*8 | Stored register image |

## Verification
Two functions can land in the same cycle: the spacing check and the pointer stage. An access can hit a channel whose pointer already names a register while the gap timer is still running. The bench provokes this by loading a pointer and then issuing the next access one cycle short of the allowed spacing. A correct design flags the violation, leaves that register's slot and the pointer unchanged, and lets the following correctly spaced access reach the same register. A second case places an access exactly on the boundary cycle, where it must be accepted.

// File: rtl/sio_regfront_pkg.sv
package sio_regfront_pkg;
  localparam int REG_W    = 8;
  localparam int NSLOT    = 16;
  localparam int IDX_VEC  = 2;
  localparam int IDX_SYNC = 7;
  localparam int IDX_DATA = 8;
  localparam int IDX_MIC  = 9;
  localparam int IDX_DPLL = 14;
  localparam int IDX_OPT  = 15;
  localparam int SLOT_ALT = 8;
  localparam int BIT_ALTSEL = 0;
  localparam int BIT_EXTRD  = 6;

  typedef enum logic [1:0] {EV_CMD = 2'd0, EV_TXD = 2'd1, EV_RST = 2'd2, EV_DPLL = 2'd3} evt_kind_e;
  typedef enum logic [1:0] {RS_LIVE = 2'd0, RS_WREG = 2'd1, RS_ZERO = 2'd2} rd_src_e;
  typedef struct packed {
    rd_src_e    src;
    logic [3:0] slot;
  } rd_route_t;

  function automatic rd_route_t route_read(input logic [3:0] idx, input logic ext);
    rd_route_t r;
    r.src  = RS_LIVE;
    r.slot = idx;
    case (idx)
      4'd12, 4'd13, 4'd15: r.src = RS_WREG;
      4'd14:               r.src = RS_ZERO;
      4'd4, 4'd5:          if (ext) r.src = RS_WREG;
      4'd9:  if (ext) begin r.src = RS_WREG; r.slot = 4'd3;  end
      4'd11: if (ext) begin r.src = RS_WREG; r.slot = 4'd10; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] write_slot(input logic [3:0] idx, input logic alt_sel);
    if (idx == 4'(IDX_SYNC) && alt_sel) return 4'(SLOT_ALT);
    return idx;
  endfunction

  function automatic logic [REG_W-1:0] store_mask(input logic [3:0] slot);
    if (slot == 4'(IDX_MIC))  return 8'h3F;
    if (slot == 4'(IDX_DPLL)) return 8'h1F;
    return 8'hFF;
  endfunction

  function automatic logic is_shared(input logic [3:0] slot);
    return (slot == 4'(IDX_VEC)) || (slot == 4'(IDX_MIC));
  endfunction
endpackage

// File: rtl/sio_gap_timer.sv
module sio_gap_timer #(
  parameter int GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ok,
  output logic busy
);
  localparam int CW = $clog2(GAP_CYC + 1);
  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);
  assign ok   = req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (ok)      cnt <= CW'(GAP_CYC - 1);
    else if (busy)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sio_wreg_bank.sv
module sio_wreg_bank
  import sio_regfront_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [CHW-1:0]             wch,
  input  logic [3:0]                 wslot,
  input  logic [REG_W-1:0]           wdata,
  output logic [NCH*NSLOT*REG_W-1:0] img
);
  logic [REG_W-1:0] mem [NCH][NSLOT];
  logic [CHW-1:0]   tgt;

  assign tgt = is_shared(wslot) ? '0 : wch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int s = 0; s < NSLOT; s++)
          mem[c][s] <= '0;
    end else if (we) begin
      mem[tgt][wslot] <= wdata & store_mask(wslot);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      if (is_shared(4'(s))) begin : g_sh
        assign img[(c*NSLOT+s)*REG_W +: REG_W] = mem[0][s];
      end else begin : g_own
        assign img[(c*NSLOT+s)*REG_W +: REG_W] = mem[c][s];
      end
    end
  end
endmodule

// File: rtl/sio_rd_mux.sv
module sio_rd_mux
  import sio_regfront_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH*NSLOT*REG_W-1:0] img,
  input  logic [CHW-1:0]             rd_ch,
  input  logic [3:0]                 idx,
  input  logic                       ext,
  input  logic [REG_W-1:0]           live_val,
  output logic [REG_W-1:0]           data
);
  rd_route_t route;
  int        base;

  always_comb begin
    route = route_read(idx, ext);
    base  = (int'(rd_ch) * NSLOT + int'(route.slot)) * REG_W;
    case (route.src)
      RS_WREG: data = img[base +: REG_W];
      RS_ZERO: data = '0;
      default: data = live_val;
    endcase
  end
endmodule

// File: rtl/sio_regfront.sv
module sio_regfront
  import sio_regfront_pkg::*;
#(
  parameter int NCH     = 2,
  parameter int GAP_CYC = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic                       acc_wr,
  input  logic                       acc_dport,
  input  logic [CHW-1:0]             acc_ch,
  input  logic [REG_W-1:0]           acc_wdata,
  output logic                       rd_valid,
  output logic [REG_W-1:0]           rd_data,
  output logic [CHW-1:0]             live_ch,
  output logic [3:0]                 live_idx,
  input  logic [REG_W-1:0]           live_val,
  output logic                       gap_viol,
  output logic                       evt_valid,
  output logic [1:0]                 evt_kind,
  output logic [CHW-1:0]             evt_ch,
  output logic [REG_W-1:0]           evt_val,
  output logic [NCH*NSLOT*REG_W-1:0] wreg_img
);
  logic [3:0]       ptr [NCH];
  logic [3:0]       cur_ptr, eff_idx, ptr_ch0;
  logic             acc_ok, busy, alt_sel, ext_rd;
  logic             bank_we;
  logic [3:0]       bank_slot;
  logic [REG_W-1:0] mux_data;
  logic             ev_v;
  evt_kind_e        ev_k;
  logic [REG_W-1:0] ev_val;

  assign cur_ptr  = ptr[acc_ch];
  assign ptr_ch0  = ptr[0];
  assign eff_idx  = acc_dport ? 4'(IDX_DATA) : cur_ptr;
  assign live_ch  = acc_ch;
  assign live_idx = eff_idx;
  assign alt_sel  = wreg_img[(int'(acc_ch) * NSLOT + IDX_OPT) * REG_W + BIT_ALTSEL];
  assign ext_rd   = wreg_img[(int'(acc_ch) * NSLOT + SLOT_ALT) * REG_W + BIT_EXTRD];

  sio_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .req(acc_valid), .ok(acc_ok), .busy(busy)
  );

  assign bank_we   = acc_ok && acc_wr && !acc_dport &&
                     (cur_ptr != 4'd0) && (cur_ptr != 4'(IDX_DATA));
  assign bank_slot = write_slot(cur_ptr, alt_sel);

  sio_wreg_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .wch(acc_ch),
    .wslot(bank_slot), .wdata(acc_wdata), .img(wreg_img)
  );

  sio_rd_mux #(.NCH(NCH)) u_rmux (
    .img(wreg_img), .rd_ch(acc_ch), .idx(eff_idx), .ext(ext_rd),
    .live_val(live_val), .data(mux_data)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr[c] <= '0;
      else if (acc_ok && !acc_dport && acc_ch == CHW'(c)) begin
        if (acc_wr && cur_ptr == 4'd0) ptr[c] <= acc_wdata[3:0];
        else                           ptr[c] <= '0;
      end
    end
  end

  always_comb begin
    ev_v   = 1'b0;
    ev_k   = EV_CMD;
    ev_val = acc_wdata;
    if (acc_ok && acc_wr) begin
      if (acc_dport || cur_ptr == 4'(IDX_DATA)) begin
        ev_v = 1'b1; ev_k = EV_TXD;
      end else if (cur_ptr == 4'd0) begin
        ev_v = 1'b1; ev_k = EV_CMD;
      end else if (cur_ptr == 4'(IDX_MIC) && acc_wdata[7:6] != 2'd0) begin
        ev_v = 1'b1; ev_k = EV_RST;  ev_val = {6'd0, acc_wdata[7:6]};
      end else if (cur_ptr == 4'(IDX_DPLL) && acc_wdata[7:5] != 3'd0) begin
        ev_v = 1'b1; ev_k = EV_DPLL; ev_val = {5'd0, acc_wdata[7:5]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      gap_viol  <= 1'b0;
      evt_valid <= 1'b0;
      evt_kind  <= '0;
      evt_ch    <= '0;
      evt_val   <= '0;
    end else begin
      rd_valid  <= acc_ok && !acc_wr;
      rd_data   <= mux_data;
      gap_viol  <= acc_valid && busy;
      evt_valid <= ev_v;
      evt_kind  <= ev_k;
      evt_ch    <= acc_ch;
      evt_val   <= ev_val;
    end
  end
endmodule

// File: rtl/sio_regfront_chk.sv
module sio_regfront_chk
  import sio_regfront_pkg::*;
#(
  parameter int NCH     = 2,
  parameter int GAP_CYC = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       acc_valid,
  input logic                       acc_wr,
  input logic                       acc_dport,
  input logic [CHW-1:0]             acc_ch,
  input logic                       acc_ok,
  input logic [3:0]                 ptr_ch0,
  input logic                       gap_viol,
  input logic                       rd_valid,
  input logic                       evt_valid,
  input logic [NCH*NSLOT*REG_W-1:0] wreg_img
);
  int since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since <= GAP_CYC;
    else if (acc_ok)          since <= 1;
    else if (since < GAP_CYC) since <= since + 1;
  end

  p_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |-> since >= GAP_CYC);

  p_viol_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gap_viol |-> (!rd_valid && !evt_valid && $stable(wreg_img)));

  p_viol_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gap_viol |-> $past(acc_valid && !acc_ok));

  p_rd_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_ok && !acc_wr));

  p_evt_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(acc_ok && acc_wr));

  p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !acc_dport && acc_ch == '0 && ptr_ch0 != 4'd0) |=> ptr_ch0 == 4'd0);

  p_dport_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && acc_dport && acc_ch == '0) |=> $stable(ptr_ch0));
endmodule

bind sio_regfront sio_regfront_chk #(.NCH(NCH), .GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wr(acc_wr),
  .acc_dport(acc_dport), .acc_ch(acc_ch), .acc_ok(acc_ok), .ptr_ch0(ptr_ch0),
  .gap_viol(gap_viol), .rd_valid(rd_valid), .evt_valid(evt_valid),
  .wreg_img(wreg_img)
);

// File: tb/sio_regfront_bench.sv
module sio_regfront_bench;
  localparam int GAP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, acc_wr = 1'b0, acc_dport = 1'b0;
  logic [0:0] acc_ch = '0;
  logic [7:0] acc_wdata = '0;
  logic       rd_valid, gap_viol, evt_valid;
  logic [7:0] rd_data, evt_val, live_val;
  logic [0:0] live_ch, evt_ch;
  logic [3:0] live_idx;
  logic [1:0] evt_kind;
  logic [255:0] wreg_img;

  int n_chk = 0, n_fail = 0;
  logic       c_rv, c_gv, c_ev;
  logic [7:0] c_rd, c_evv;
  logic [1:0] c_evk;
  logic [0:0] c_evc;

  always #10 clk = ~clk;

  assign live_val = {3'b101, live_ch, live_idx};

  sio_regfront #(.NCH(2), .GAP_CYC(GAP)) u_sio_regfront (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wr(acc_wr),
    .acc_dport(acc_dport), .acc_ch(acc_ch), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .live_ch(live_ch),
    .live_idx(live_idx), .live_val(live_val), .gap_viol(gap_viol),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_ch(evt_ch),
    .evt_val(evt_val), .wreg_img(wreg_img)
  );

  function automatic logic [7:0] exp_live(input int ch, input int idx);
    return {3'b101, 1'(ch), 4'(idx)};
  endfunction

  function automatic logic [7:0] slot(input int ch, input int s);
    return wreg_img[(ch*16+s)*8 +: 8];
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic dp, input int ch, input logic [7:0] d,
                     input int pad = GAP - 2);
    @(negedge clk);
    acc_valid = 1'b1; acc_wr = wr; acc_dport = dp; acc_ch = 1'(ch); acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
    c_rv = rd_valid; c_rd = rd_data; c_gv = gap_viol;
    c_ev = evt_valid; c_evk = evt_kind; c_evc = evt_ch; c_evv = evt_val;
    repeat (pad) @(negedge clk);
  endtask

  task automatic wr_reg(input int ch, input int idx, input logic [7:0] d);
    acc(1, 0, ch, 8'(idx));
    acc(1, 0, ch, d);
  endtask

  task automatic rd_reg(input int ch, input int idx);
    acc(1, 0, ch, 8'(idx));
    acc(0, 0, ch, 8'h00);
  endtask

  task automatic t_reset;
    chk(wreg_img == '0, "R1 image zero", int'(|wreg_img), 0);
    chk(!rd_valid && !evt_valid && !gap_viol, "R1 outputs idle",
        int'({rd_valid, evt_valid, gap_viol}), 0);
    acc(0, 0, 0, 8'h00);
    chk(c_rv && c_rd == exp_live(0, 0), "R1 pointer zero read", c_rd, exp_live(0, 0));
  endtask

  task automatic t_pointer;
    acc(1, 0, 0, 8'h35);
    chk(c_ev && c_evk == 2'd0 && c_evv == 8'h35, "R2 command event", c_evv, 8'h35);
    acc(1, 0, 1, 8'h03);
    acc(1, 0, 0, 8'hA7);
    chk(slot(0, 5) == 8'hA7, "R2 pointed write ch0", slot(0, 5), 8'hA7);
    chk(!c_ev, "R11 no event for plain store", int'(c_ev), 0);
    acc(1, 0, 1, 8'h6B);
    chk(slot(1, 3) == 8'h6B, "R2 independent ch1 pointer", slot(1, 3), 8'h6B);
    acc(0, 0, 0, 8'h00);
    chk(c_rv && c_rd == exp_live(0, 0), "R2 pointer back at zero", c_rd, exp_live(0, 0));
  endtask

  task automatic t_dataport;
    acc(1, 0, 1, 8'h0C);
    acc(1, 1, 1, 8'h5A);
    chk(c_ev && c_evk == 2'd1 && c_evc == 1'b1 && c_evv == 8'h5A, "R3 data write",
        {c_evk, c_evv}, {2'd1, 8'h5A});
    acc(0, 1, 1, 8'h00);
    chk(c_rv && c_rd == exp_live(1, 8), "R3 data read", c_rd, exp_live(1, 8));
    acc(1, 0, 1, 8'h99);
    chk(slot(1, 12) == 8'h99, "R3 pointer kept across data port", slot(1, 12), 8'h99);
    wr_reg(0, 8, 8'h3E);
    chk(c_ev && c_evk == 2'd1 && c_evv == 8'h3E, "R3 control index 8 transmit", c_evv, 8'h3E);
  endtask

  task automatic t_shared;
    wr_reg(1, 2, 8'h44);
    chk(slot(0, 2) == 8'h44 && slot(1, 2) == 8'h44, "R4 shared vector", slot(0, 2), 8'h44);
    wr_reg(0, 9, 8'h15);
    chk(slot(0, 9) == 8'h15 && slot(1, 9) == 8'h15, "R4 shared master", slot(1, 9), 8'h15);
  endtask

  task automatic t_alt;
    wr_reg(0, 7, 8'h11);
    chk(slot(0, 7) == 8'h11 && slot(0, 8) == 8'h00, "R5 sync slot", slot(0, 7), 8'h11);
    wr_reg(0, 15, 8'h01);
    wr_reg(0, 7, 8'h22);
    chk(slot(0, 8) == 8'h22 && slot(0, 7) == 8'h11, "R5 alternate slot", slot(0, 8), 8'h22);
  endtask

  task automatic t_readback;
    wr_reg(0, 4, 8'h4A); wr_reg(0, 5, 8'h5B); wr_reg(0, 3, 8'h3C);
    wr_reg(0, 10, 8'hA0); wr_reg(0, 12, 8'hC1); wr_reg(0, 13, 8'hD2);
    rd_reg(0, 4);  chk(c_rd == exp_live(0, 4), "R6 idx4 live when off", c_rd, exp_live(0, 4));
    rd_reg(0, 9);  chk(c_rd == exp_live(0, 9), "R6 idx9 live when off", c_rd, exp_live(0, 9));
    rd_reg(0, 12); chk(c_rd == 8'hC1, "R7 idx12", c_rd, 8'hC1);
    rd_reg(0, 13); chk(c_rd == 8'hD2, "R7 idx13", c_rd, 8'hD2);
    rd_reg(0, 15); chk(c_rd == 8'h01, "R7 idx15", c_rd, 8'h01);
    rd_reg(0, 14); chk(c_rv && c_rd == 8'h00, "R7 idx14 zero", c_rd, 0);
    rd_reg(0, 6);  chk(c_rd == exp_live(0, 6), "R7 idx6 live", c_rd, exp_live(0, 6));
    wr_reg(0, 7, 8'h40);
    rd_reg(0, 4);  chk(c_rd == 8'h4A, "R6 idx4 readback", c_rd, 8'h4A);
    rd_reg(0, 5);  chk(c_rd == 8'h5B, "R6 idx5 readback", c_rd, 8'h5B);
    rd_reg(0, 9);  chk(c_rd == 8'h3C, "R6 idx9 gives slot3", c_rd, 8'h3C);
    rd_reg(0, 11); chk(c_rd == 8'hA0, "R6 idx11 gives slot10", c_rd, 8'hA0);
    rd_reg(1, 4);  chk(c_rd == exp_live(1, 4), "R6 ch1 unaffected", c_rd, exp_live(1, 4));
  endtask

  task automatic t_reset_cmd;
    wr_reg(1, 9, 8'hC7);
    chk(c_ev && c_evk == 2'd2 && c_evv == 8'd3 && c_evc == 1'b1, "R8 hardware reset event",
        c_evv, 3);
    chk(slot(0, 9) == 8'h07, "R8 stored low bits", slot(0, 9), 8'h07);
    wr_reg(1, 9, 8'h2A);
    chk(!c_ev && slot(1, 9) == 8'h2A, "R8 no event without code", slot(1, 9), 8'h2A);
  endtask

  task automatic t_dpll;
    wr_reg(1, 14, 8'hFF);
    chk(c_ev && c_evk == 2'd3 && c_evv == 8'd7, "R9 clock command event", c_evv, 7);
    chk(slot(1, 14) == 8'h1F, "R9 stored low bits", slot(1, 14), 8'h1F);
  endtask

  task automatic t_gap;
    acc(1, 0, 0, 8'h0D, 0);
    acc(1, 0, 0, 8'h77);
    chk(c_gv && !c_ev, "R10 early access flagged", int'(c_gv), 1);
    chk(slot(0, 13) == 8'hD2, "R10 early write ignored", slot(0, 13), 8'hD2);
    acc(1, 0, 0, 8'h66);
    chk(!c_gv && slot(0, 13) == 8'h66, "R10 pointer survived rejection", slot(0, 13), 8'h66);
    acc(1, 0, 0, 8'h0C, GAP - 3);
    acc(0, 0, 0, 8'h00);
    chk(c_gv && !c_rv, "R10 one cycle short rejected", int'(c_gv), 1);
    acc(1, 0, 0, 8'h6E);
    chk(slot(0, 12) == 8'h6E, "R10 next spaced access uses pointer", slot(0, 12), 8'h6E);
    acc(1, 0, 0, 8'h00, GAP - 2);
    acc(0, 0, 0, 8'h00);
    chk(!c_gv && c_rv && c_rd == exp_live(0, 0), "R10 exact spacing accepted",
        c_rd, exp_live(0, 0));
    @(negedge clk);
    chk(!rd_valid && !evt_valid, "R11 single-cycle outputs", int'(rd_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_pointer;
    t_dataport;
    t_shared;
    t_alt;
    t_readback;
    t_reset_cmd;
    t_dpll;
    t_gap;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule